// File: doc/BRIEF.md
# Sector Signature Hash Engine

The engine turns each fixed-length disk sector into a 64-bit signature, one byte per clock. Bytes arrive on a valid/ready stream. A start marker travels with the first byte of each sector. A one-bit mode input picks one of two multiply-add string hashes. The engine reads the mode when a sector starts and keeps that choice to the end of the sector. The sector length is fixed, so no length word and no padding block are folded in. The signature appears as soon as the last byte has been absorbed.

Every signature carries a three-bit slot number. The slot number gives the position of the sector inside a cluster of eight consecutive sectors. A downstream lookup can use it to pick the per-position signature table. The slot count advances once for each completed sector and wraps after the eighth. A synchronous cluster-restart input puts it back to zero. A start marker that arrives before the current sector is complete throws away the partial hash, raises a one-cycle error pulse and begins a new sector with the marked byte.

Top module: `sec_sig_engine`

## Requirements
- R1: With mode_i = 0 sampled on the start byte, the accumulator starts from 5381, and each byte b of the sector updates it as h = h*33 + b, modulo 2^64.
- R2: With mode_i = 1 sampled on the start byte, the accumulator starts from 0, and each byte updates it as h = h*65599 + b, modulo 2^64.
- R3: A sector is exactly 512 accepted bytes; a byte is accepted when in_valid and in_ready are both 1, and idle cycles between bytes have no effect. sig_valid is 1 for exactly the one cycle after the 512th byte is accepted, and sig_value then holds the hash of those 512 bytes, with nothing appended.
- R4: in_ready is 0 while rst_n is low and 1 from the first clock edge after reset is released.
- R5: sig_slot gives the slot of the completed sector; it is 0 for the first sector and then counts 0,1,...,7,0 with each completed sector.
- R6: clus_rst = 1 on a clock edge makes the next completed sector carry slot 0; if clus_rst coincides with the acceptance of a 512th byte, that sector keeps its own slot and the following sector carries slot 0.
- R7: A start byte accepted while a sector is partly received discards the partial hash, pulses err_short for the one following cycle, does not advance the slot, and starts a new sector with that byte; otherwise err_short stays 0.
- R8: Bytes accepted with in_sos = 0 outside a sector are ignored: no signature, no error, and no effect on the next sector.
- R9: Changes of mode_i after the start byte of a sector have no effect on that sector's signature.
- R10: After reset, sig_valid and err_short are 0 and the first sector completed carries slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clus_rst | input | 1 | Synchronous restart of the cluster slot count |
| mode_i | input | 1 | Hash variant: 0 = multiplier 33 with seed 5381, 1 = multiplier 65599 with seed 0 |
| in_valid | input | 1 | Byte on in_byte is valid |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_sos | input | 1 | Byte is the first of a sector |
| in_byte | input | 8 | Sector data byte |
| sig_valid | output | 1 | One-cycle strobe: signature available |
| sig_value | output | 64 | Sector signature |
| sig_slot | output | 3 | Position of the sector inside its cluster |
| err_short | output | 1 | One-cycle pulse: sector cut short by a new start marker |

## Verification
Sectors of all-zero, all-ones, ramp and pseudo-random bytes are hashed in both modes. The zero sector shows the seed and multiplier on their own. The ramp and random sectors expose errors in the shift-add terms and in carry across the 64-bit wrap. Sectors sent with idle gaps, with the mode toggling after the start, after a run of stray unmarked bytes, or right after an aborted partial sector must match the clean result. This separates correct framing from byte loss or leakage. Nine back-to-back sectors, and cluster restarts both between sectors and on a final byte, tell apart the slot wrap and the priority of the restart over the increment.

// File: rtl/sec_sig_pkg.sv
package sec_sig_pkg;

  localparam int HASH_W = 64;
  localparam int BYTE_W = 8;

  localparam logic [HASH_W-1:0] SEED_A = 64'd5381;
  localparam logic [HASH_W-1:0] SEED_B = 64'd0;
  localparam logic [HASH_W-1:0] MULT_A = 64'd33;
  localparam logic [HASH_W-1:0] MULT_B = 64'd65599;

  typedef enum logic {
    HMODE_A = 1'b0,
    HMODE_B = 1'b1
  } hmode_e;

  function automatic logic [HASH_W-1:0] seed_of(hmode_e m);
    return (m == HMODE_A) ? SEED_A : SEED_B;
  endfunction

  function automatic logic [HASH_W-1:0] mult_of(hmode_e m);
    return (m == HMODE_A) ? MULT_A : MULT_B;
  endfunction

  function automatic logic [HASH_W-1:0] widen(logic [BYTE_W-1:0] b);
    logic [HASH_W-1:0] w;
    w = '0;
    w[BYTE_W-1:0] = b;
    return w;
  endfunction

  // 33 = 2^5 + 1 ; 65599 = 2^16 + 2^6 - 1
  function automatic logic [HASH_W-1:0] step_shift(hmode_e m,
                                                   logic [HASH_W-1:0] h,
                                                   logic [BYTE_W-1:0] b);
    logic [HASH_W-1:0] r;
    if (m == HMODE_A) r = (h << 5) + h;
    else              r = (h << 16) + (h << 6) - h;
    return r + widen(b);
  endfunction

endpackage

// File: rtl/sec_sig_step.sv
import sec_sig_pkg::*;

module sec_sig_step #(
  parameter bit USE_MUL = 1'b0
) (
  input  hmode_e                mode,
  input  logic                  restart,
  input  logic [HASH_W-1:0]     acc_in,
  input  logic [BYTE_W-1:0]     byte_in,
  output logic [HASH_W-1:0]     acc_out
);

  logic [HASH_W-1:0] base;

  assign base = restart ? seed_of(mode) : acc_in;

  generate
    if (USE_MUL) begin : g_mul
      assign acc_out = base * mult_of(mode) + widen(byte_in);
    end else begin : g_shift
      assign acc_out = step_shift(mode, base, byte_in);
    end
  endgenerate

endmodule

// File: rtl/sec_sig_frame.sv
module sec_sig_frame #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sos,
  output logic use_byte,
  output logic sec_start,
  output logic sec_last,
  output logic sec_abort
);

  localparam int CNT_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SECTOR_BYTES - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;

  assign sec_start = take && sos;
  assign sec_abort = sec_start && active_q;
  assign use_byte  = take && (active_q || sos);
  assign pos       = sos ? '0 : cnt_q;
  assign sec_last  = use_byte && (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (use_byte) begin
      if (sec_last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        active_q <= 1'b1;
        cnt_q    <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sec_sig_slot.sv
module sec_sig_slot #(
  parameter int CLUSTER_SECTORS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic [((CLUSTER_SECTORS > 1) ? $clog2(CLUSTER_SECTORS) : 1)-1:0] slot
);

  localparam int SLOT_W = (CLUSTER_SECTORS > 1) ? $clog2(CLUSTER_SECTORS) : 1;
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(CLUSTER_SECTORS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slot <= '0;
    else if (clr)      slot <= '0;
    else if (adv)      slot <= (slot == TOP) ? '0 : slot + 1'b1;
  end

endmodule

// File: rtl/sec_sig_engine.sv
import sec_sig_pkg::*;

module sec_sig_engine #(
  parameter int SECTOR_BYTES    = 512,
  parameter int CLUSTER_SECTORS = 8,
  parameter bit USE_MUL         = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clus_rst,
  input  logic        mode_i,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sos,
  input  logic [7:0]  in_byte,
  output logic        sig_valid,
  output logic [63:0] sig_value,
  output logic [2:0]  sig_slot,
  output logic        err_short
);

  localparam int SLOT_W = (CLUSTER_SECTORS > 1) ? $clog2(CLUSTER_SECTORS) : 1;

  logic              ready_q;
  logic              byte_take;
  logic              use_byte;
  logic              sec_start;
  logic              sec_last;
  logic              sec_abort;
  hmode_e            mode_q;
  hmode_e            mode_eff;
  logic [HASH_W-1:0] acc_q;
  logic [HASH_W-1:0] acc_nx;
  logic [SLOT_W-1:0] slot_q;

  assign in_ready  = ready_q;
  assign byte_take = in_valid && ready_q;
  assign mode_eff  = in_sos ? hmode_e'(mode_i) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  sec_sig_frame #(
    .SECTOR_BYTES(SECTOR_BYTES)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (byte_take),
    .sos      (in_sos),
    .use_byte (use_byte),
    .sec_start(sec_start),
    .sec_last (sec_last),
    .sec_abort(sec_abort)
  );

  sec_sig_step #(
    .USE_MUL(USE_MUL)
  ) u_step (
    .mode   (mode_eff),
    .restart(in_sos),
    .acc_in (acc_q),
    .byte_in(in_byte),
    .acc_out(acc_nx)
  );

  sec_sig_slot #(
    .CLUSTER_SECTORS(CLUSTER_SECTORS)
  ) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (sec_last),
    .clr  (clus_rst),
    .slot (slot_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= HMODE_A;
      acc_q  <= '0;
    end else begin
      if (sec_start) mode_q <= mode_eff;
      if (use_byte)  acc_q  <= acc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_valid <= 1'b0;
      sig_value <= '0;
      sig_slot  <= '0;
      err_short <= 1'b0;
    end else begin
      sig_valid <= sec_last;
      err_short <= sec_abort;
      if (sec_last) begin
        sig_value <= acc_nx;
        sig_slot  <= 3'(slot_q);
      end
    end
  end

endmodule

// File: rtl/sec_sig_chk.sv
module sec_sig_chk #(
  parameter int CLUSTER_SECTORS = 8,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clus_rst,
  input logic              in_ready,
  input logic              sig_valid,
  input logic              err_short,
  input logic              sec_last,
  input logic              sec_abort,
  input logic [SLOT_W-1:0] slot_q
);

  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(CLUSTER_SECTORS - 1);

  // R3
  last_then_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_last |=> sig_valid);

  // R3
  sig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |=> !sig_valid);

  // R7
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_abort |=> err_short);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |-> !sig_valid);

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_last && !clus_rst) |=>
      (slot_q == (($past(slot_q) == TOP) ? '0 : $past(slot_q) + 1'b1)));

  // R6
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clus_rst |=> (slot_q == '0));

  // R4
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

endmodule

bind sec_sig_engine sec_sig_chk #(
  .CLUSTER_SECTORS(CLUSTER_SECTORS),
  .SLOT_W(SLOT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clus_rst (clus_rst),
  .in_ready (in_ready),
  .sig_valid(sig_valid),
  .err_short(err_short),
  .sec_last (sec_last),
  .sec_abort(sec_abort),
  .slot_q   (slot_q)
);

// File: tb/sec_sig_engine_tb.sv
`timescale 1ns/1ps
module sec_sig_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clus_rst = 1'b0;
  logic        mode_i = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sos = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        sig_valid;
  logic [63:0] sig_value;
  logic [2:0]  sig_slot;
  logic        err_short;

  int errors = 0;
  int checks = 0;
  int exp_slot = 0;
  logic [7:0] sec_buf [512];

  always #5 clk = ~clk;

  sec_sig_engine u_dut (
    .clk(clk), .rst_n(rst_n), .clus_rst(clus_rst), .mode_i(mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_sos(in_sos),
    .in_byte(in_byte), .sig_valid(sig_valid), .sig_value(sig_value),
    .sig_slot(sig_slot), .err_short(err_short)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent model: plain multiply, 64-bit wrap
  function automatic logic [63:0] ref_hash(input bit m);
    logic [63:0] h;
    h = m ? 64'd0 : 64'd5381;
    for (int i = 0; i < 512; i++)
      h = h * (m ? 64'd65599 : 64'd33) + 64'(sec_buf[i]);
    return h;
  endfunction

  // kind: 0 zeros, 1 ones, 2 ramp, 3 pseudo-random
  task automatic fill(input int kind, input logic [31:0] seed);
    logic [31:0] x;
    x = seed;
    for (int i = 0; i < 512; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      case (kind)
        0: sec_buf[i] = 8'h00;
        1: sec_buf[i] = 8'hFF;
        2: sec_buf[i] = 8'(i);
        default: sec_buf[i] = x[23:16];
      endcase
    end
  endtask

  task automatic send(input bit m, input int gap, input bit flip,
                      input bit rst_last, input bit exp_err, input string req);
    for (int i = 0; i < 512; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hA5;
        in_sos   = (g % 2 == 0);
        mode_i   = ~m;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sos   = (i == 0);
      in_byte  = sec_buf[i];
      mode_i   = (i == 0) ? m : (flip ? ((i % 2) ? ~m : m) : m);
      clus_rst = rst_last && (i == 511);
      if (i == 0) begin
        @(posedge clk);
        #2;
        chk(err_short == exp_err, "R7 err_short after start byte",
            64'(err_short), 64'(exp_err));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sos   = 1'b0;
    clus_rst = 1'b0;
    chk(sig_valid == 1'b1, {req, " R3 sig_valid"}, 64'(sig_valid), 64'd1);
    chk(sig_value == ref_hash(m), {req, " signature"}, sig_value, ref_hash(m));
    chk(sig_slot == 3'(exp_slot), {req, " R5 slot"}, 64'(sig_slot), 64'(exp_slot));
    exp_slot = rst_last ? 0 : (exp_slot + 1) % 8;
    @(negedge clk);
    chk(sig_valid == 1'b0, "R3 single-cycle strobe", 64'(sig_valid), 64'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R4 ready low in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready after reset", 64'(in_ready), 64'd1);
    chk(sig_valid == 1'b0, "R10 sig_valid reset", 64'(sig_valid), 64'd0);
    chk(err_short == 1'b0, "R10 err_short reset", 64'(err_short), 64'd0);
  endtask

  task automatic t_basic;
    fill(0, 0);  send(1'b0, 0, 1'b0, 1'b0, 1'b0, "R1 R10 zeros");
    fill(0, 0);  send(1'b1, 0, 1'b0, 1'b0, 1'b0, "R2 zeros");
    fill(2, 0);  send(1'b0, 0, 1'b0, 1'b0, 1'b0, "R1 ramp");
    fill(2, 0);  send(1'b1, 0, 1'b0, 1'b0, 1'b0, "R2 ramp");
    fill(1, 0);  send(1'b1, 0, 1'b0, 1'b0, 1'b0, "R2 ones");
    fill(3, 7);  send(1'b0, 0, 1'b0, 1'b0, 1'b0, "R1 random");
    fill(3, 99); send(1'b1, 0, 1'b0, 1'b0, 1'b0, "R2 random");
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 3; k++) begin
      fill(3, 32'(k + 200));
      send(k[0], 0, 1'b0, 1'b0, 1'b0, "R5 wrap run");
    end
  endtask

  task automatic t_gaps_flip;
    fill(3, 55); send(1'b1, 2, 1'b0, 1'b0, 1'b0, "R3 idle gaps");
    fill(3, 56); send(1'b0, 0, 1'b1, 1'b0, 1'b0, "R9 mode toggling A");
    fill(3, 57); send(1'b1, 0, 1'b1, 1'b0, 1'b0, "R9 mode toggling B");
  endtask

  task automatic t_abort;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sos   = (i == 0);
      in_byte  = 8'(i * 7 + 3);
      mode_i   = 1'b1;
    end
    fill(3, 77);
    send(1'b0, 0, 1'b0, 1'b0, 1'b1, "R7 after abort");
  endtask

  task automatic t_stray;
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sig_valid || err_short) seen = 1'b1;
      in_valid = 1'b1;
      in_sos   = 1'b0;
      in_byte  = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (sig_valid || err_short) seen = 1'b1;
    chk(!seen, "R8 stray bytes produce nothing", 64'(seen), 64'd0);
    fill(2, 0);
    send(1'b1, 0, 1'b0, 1'b0, 1'b0, "R8 sector after stray");
  endtask

  task automatic t_clus;
    @(negedge clk);
    clus_rst = 1'b1;
    @(negedge clk);
    clus_rst = 1'b0;
    exp_slot = 0;
    fill(3, 11); send(1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 after idle restart");
    fill(3, 12); send(1'b1, 0, 1'b0, 1'b1, 1'b0, "R6 restart on last byte");
    fill(3, 13); send(1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 slot after coincident");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_gaps_flip();
    t_abort();
    t_stray();
    t_clus();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule